// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block links two processors, called side A and side B, each through its own simple register port. Each side owns four 32-bit outgoing message slots, and each slot feeds the matching incoming slot on the other side. Every slot carries a handshake. A write fills the slot, which clears the sender's empty bit and sets the receiver's full bit. A read of the incoming slot drains it, which clears the full bit and sets the sender's empty bit again.

Each side also publishes a 3-bit flag field to its peer. After an accepted change, a busy bit stays up for a fixed two-cycle propagation window. The new value appears on the peer when the busy bit drops. While busy is set, further flag writes are dropped. A side can also post four general interrupt requests and one non-maskable request to its peer. Each posted request stays pending until the peer writes 1 to the matching bit of its own status word. Each side has an interrupt output, which is the OR of its enabled conditions, and a separate non-maskable output.

Word addresses on each port: 0-3 are outgoing slots 0-3 (write), 4-7 are incoming slots 0-3 (read), 8 is STATUS, and 9 is CONTROL. The read data always shows the word selected by the address. Only a read strobe on an incoming slot has a side effect.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, STATUS on both sides reads 0x000000F0 (all empty bits set, nothing full, not busy, nothing pending). CONTROL reads 0, and the irq and nmi outputs are low.
- R2: A write to outgoing slot n clears STATUS bit 7-n (empty) on the writing side. It sets STATUS bit 3-n (full) on the other side.
- R3: A read-strobed access to incoming slot n returns the last word written to the peer's outgoing slot n. The access clears the reader's full bit 3-n and sets the peer's empty bit 7-n.
- R4: Slots and directions are independent. Traffic in several slots in both directions leaves each bit set only by its own slot.
- R5: A CONTROL write that changes the flag field (CONTROL[2:0]) sets STATUS bit 8 (busy) on the writer in the next cycle. Busy stays set for exactly two cycles. When busy clears, the value appears in the peer's STATUS[11:9].
- R6: A flag write made while busy is set is ignored. Neither the writer's CONTROL[2:0] nor the peer's STATUS[11:9] takes that value.
- R7: Writing 1 to CONTROL bit 7-j posts general request j. The request then reads as 1 in the sender's CONTROL and in the peer's STATUS bit 15-j. Writing 0 to a posted bit leaves it pending.
- R8: The peer writing 1 to its STATUS bit 15-j accepts request j. This clears the bit in both places.
- R9: Writing 1 to CONTROL bit 8 posts a non-maskable request. It drives the peer's nmi output and the peer's STATUS bit 16 until the peer writes 1 to its STATUS bit 16.
- R10: irq is high exactly when one of these holds: CONTROL bit 9 is set and some incoming slot is full; CONTROL bit 10 is set and some outgoing slot is empty; CONTROL bit 11 is set and some general request from the peer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe (drains incoming slots) |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data for the addressed word |
| a_irq | output | 1 | Side A interrupt |
| a_nmi | output | 1 | Side A non-maskable request from side B |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe (drains incoming slots) |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data for the addressed word |
| b_irq | output | 1 | Side B interrupt |
| b_nmi | output | 1 | Side B non-maskable request from side A |

## Verification
The slot handshake is tested first with one message in a middle slot, which shows whether the bit order puts slot 0 at the top of each group. It is then tested with mixed traffic in slots 0, 2 and 3 in both directions, which separates a crossed direction or a shared full bit from the correct per-slot wiring. The flag field is observed cycle by cycle after a single write, to pin down the two-cycle busy window. A back-to-back second write inside that window shows whether the lock holds. For requests, a zero-write, an acceptance by the peer and each interrupt enable in isolation distinguish sticky-pending behaviour from plain register storage.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam int unsigned MB_NREG = 4;
  localparam int unsigned MB_DW   = 32;
  localparam int unsigned MB_FW   = 3;
  localparam int unsigned MB_NGI  = 4;
  localparam int unsigned MB_LAT  = 2;
  localparam int unsigned MB_AW   = 4;
endpackage

// File: rtl/mb_dir.sv
// One direction of traffic: sender slots, full bits, flag mirror and requests.
module mb_dir #(
  parameter int unsigned NREG = mb_pkg::MB_NREG,
  parameter int unsigned DW   = mb_pkg::MB_DW,
  parameter int unsigned FW   = mb_pkg::MB_FW,
  parameter int unsigned NGI  = mb_pkg::MB_NGI,
  parameter int unsigned LAT  = mb_pkg::MB_LAT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           tx_we,
  input  logic [DW-1:0]             tx_data,
  input  logic [NREG-1:0]           rx_re,
  input  logic                      flag_we,
  input  logic [FW-1:0]             flag_val,
  input  logic [NGI:0]              req_set,
  input  logic [NGI:0]              req_acc,
  output logic [NREG-1:0][DW-1:0]   msg,
  output logic [NREG-1:0]           full,
  output logic [FW-1:0]             flags_src,
  output logic                      busy,
  output logic [FW-1:0]             mirror,
  output logic [NGI:0]              pend
);
  localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(LAT - 1);

  logic [NREG-1:0] full_d;
  logic [FW-1:0]   src_d, mir_d;
  logic            busy_d, take;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [NGI:0]    pend_d;

  for (genvar n = 0; n < NREG; n++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          msg[n] <= '0;
      else if (tx_we[n])   msg[n] <= tx_data;
    end

    // R2
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full[n]) |-> $past(tx_we[n]));
  end

  assign full_d = (full & ~rx_re) | tx_we;
  assign take   = flag_we && !busy && (flag_val != flags_src);
  assign pend_d = (pend & ~req_acc) | req_set;

  always_comb begin
    src_d  = flags_src;
    busy_d = busy;
    cnt_d  = cnt_q;
    mir_d  = mirror;
    if (take) begin
      src_d  = flag_val;
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy) begin
      if (cnt_q == CNT_LAST) begin
        busy_d = 1'b0;
        mir_d  = flags_src;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= '0;
      flags_src <= '0;
      busy      <= 1'b0;
      cnt_q     <= '0;
      mirror    <= '0;
      pend      <= '0;
    end else begin
      full      <= full_d;
      flags_src <= src_d;
      busy      <= busy_d;
      cnt_q     <= cnt_d;
      mirror    <= mir_d;
      pend      <= pend_d;
    end
  end

  // R5
  mirror_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mirror == flags_src));

  // R6
  flag_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && flag_we) |=> $stable(flags_src));

  for (genvar j = 0; j <= NGI; j++) begin : g_req
    // R7
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[j] && !req_acc[j]) |=> pend[j]);
  end
endmodule

// File: rtl/mb_side.sv
// Register decode, read mux, enables and interrupt for one side.
module mb_side #(
  parameter int unsigned NREG = mb_pkg::MB_NREG,
  parameter int unsigned DW   = mb_pkg::MB_DW,
  parameter int unsigned FW   = mb_pkg::MB_FW,
  parameter int unsigned NGI  = mb_pkg::MB_NGI,
  parameter int unsigned AW   = mb_pkg::MB_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    irq,
  output logic                    nmi,
  input  logic [NREG-1:0]         out_full,
  input  logic [FW-1:0]           out_src,
  input  logic                    out_busy,
  input  logic [NGI:0]            out_pend,
  input  logic [NREG-1:0][DW-1:0] in_msg,
  input  logic [NREG-1:0]         in_full,
  input  logic [FW-1:0]           in_mirror,
  input  logic [NGI:0]            in_pend,
  output logic [NREG-1:0]         tx_we,
  output logic [NREG-1:0]         rx_re,
  output logic                    flag_we,
  output logic [FW-1:0]           flag_val,
  output logic [NGI:0]            req_set,
  output logic [NGI:0]            req_acc
);
  localparam int unsigned ST_BUSY   = 2 * NREG;
  localparam int unsigned ST_GI_TOP = 2 * NREG + FW + NGI;
  localparam int unsigned ST_NMI    = ST_GI_TOP + 1;
  localparam int unsigned CT_GI_TOP = FW + NGI;
  localparam int unsigned CT_NMI    = CT_GI_TOP + 1;
  localparam int unsigned CT_EN     = CT_NMI + 1;
  localparam logic [AW-1:0] A_ST = AW'(2 * NREG);
  localparam logic [AW-1:0] A_CT = AW'(2 * NREG + 1);

  logic          st_we, ct_we;
  logic [2:0]    en_q, en_d;
  logic [DW-1:0] status, ctrl;

  assign st_we    = wr && (addr == A_ST);
  assign ct_we    = wr && (addr == A_CT);
  assign flag_we  = ct_we;
  assign flag_val = wdata[FW-1:0];
  assign en_d     = ct_we ? wdata[CT_EN +: 3] : en_q;

  for (genvar n = 0; n < NREG; n++) begin : g_dec
    assign tx_we[n] = wr && (addr == AW'(n));
    assign rx_re[n] = rd && (addr == AW'(NREG + n));
  end

  for (genvar j = 0; j < NGI; j++) begin : g_req
    assign req_set[j] = ct_we && wdata[CT_GI_TOP - j];
    assign req_acc[j] = st_we && wdata[ST_GI_TOP - j];
  end
  assign req_set[NGI] = ct_we && wdata[CT_NMI];
  assign req_acc[NGI] = st_we && wdata[ST_NMI];

  always_comb begin
    status = '0;
    ctrl   = '0;
    for (int n = 0; n < NREG; n++) begin
      status[2*NREG-1-n] = ~out_full[n];
      status[NREG-1-n]   = in_full[n];
    end
    status[ST_BUSY]          = out_busy;
    status[ST_BUSY+1 +: FW]  = in_mirror;
    for (int j = 0; j < NGI; j++) begin
      status[ST_GI_TOP-j] = in_pend[j];
      ctrl[CT_GI_TOP-j]   = out_pend[j];
    end
    status[ST_NMI]   = in_pend[NGI];
    ctrl[FW-1:0]     = out_src;
    ctrl[CT_NMI]     = out_pend[NGI];
    ctrl[CT_EN +: 3] = en_q;
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NREG; n++) begin
      if (addr == AW'(NREG + n)) rdata = in_msg[n];
    end
    if (addr == A_ST) rdata = status;
    if (addr == A_CT) rdata = ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign irq = (en_q[0] && |in_full) || (en_q[1] && |(~out_full)) ||
               (en_q[2] && |in_pend[NGI-1:0]);
  assign nmi = in_pend[NGI];

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 3'b000) |-> !irq);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int unsigned NREG = mb_pkg::MB_NREG,
  parameter int unsigned DW   = mb_pkg::MB_DW,
  parameter int unsigned FW   = mb_pkg::MB_FW,
  parameter int unsigned NGI  = mb_pkg::MB_NGI,
  parameter int unsigned LAT  = mb_pkg::MB_LAT,
  parameter int unsigned AW   = mb_pkg::MB_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  output logic          a_nmi,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq,
  output logic          b_nmi
);
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // index 0: A sends to B, index 1: B sends to A
  logic [1:0][NREG-1:0]         tx_we, rx_re, full;
  logic [1:0][NREG-1:0][DW-1:0] msg;
  logic [1:0]                   flag_we, busy;
  logic [1:0][FW-1:0]           flag_val, src, mirror;
  logic [1:0][NGI:0]            req_set, req_acc, pend;
  logic [1:0]                   wr_s, rd_s, irq_s, nmi_s;
  logic [1:0][AW-1:0]           addr_s;
  logic [1:0][DW-1:0]           wdata_s, rdata_s;

  assign wr_s    = {b_wr, a_wr};
  assign rd_s    = {b_rd, a_rd};
  assign addr_s  = {b_addr, a_addr};
  assign wdata_s = {b_wdata, a_wdata};
  assign a_rdata = rdata_s[0];
  assign b_rdata = rdata_s[1];
  assign a_irq   = irq_s[0];
  assign b_irq   = irq_s[1];
  assign a_nmi   = nmi_s[0];
  assign b_nmi   = nmi_s[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    // direction s is sent by side s; side s receives direction 1-s
    mb_dir #(.NREG(NREG), .DW(DW), .FW(FW), .NGI(NGI), .LAT(LAT)) u_dir (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .tx_we    (tx_we[s]),
      .tx_data  (wdata_s[s]),
      .rx_re    (rx_re[1-s]),
      .flag_we  (flag_we[s]),
      .flag_val (flag_val[s]),
      .req_set  (req_set[s]),
      .req_acc  (req_acc[1-s]),
      .msg      (msg[s]),
      .full     (full[s]),
      .flags_src(src[s]),
      .busy     (busy[s]),
      .mirror   (mirror[s]),
      .pend     (pend[s])
    );

    mb_side #(.NREG(NREG), .DW(DW), .FW(FW), .NGI(NGI), .AW(AW)) u_side (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .wr       (wr_s[s]),
      .rd       (rd_s[s]),
      .addr     (addr_s[s]),
      .wdata    (wdata_s[s]),
      .rdata    (rdata_s[s]),
      .irq      (irq_s[s]),
      .nmi      (nmi_s[s]),
      .out_full (full[s]),
      .out_src  (src[s]),
      .out_busy (busy[s]),
      .out_pend (pend[s]),
      .in_msg   (msg[1-s]),
      .in_full  (full[1-s]),
      .in_mirror(mirror[1-s]),
      .in_pend  (pend[1-s]),
      .tx_we    (tx_we[s]),
      .rx_re    (rx_re[s]),
      .flag_we  (flag_we[s]),
      .flag_val (flag_val[s]),
      .req_set  (req_set[s]),
      .req_acc  (req_acc[s])
    );
  end
endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [3:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, a_nmi, b_irq, b_nmi;
  int          total = 0;
  int          bad = 0;

  localparam logic [3:0] ST = 4'd8;
  localparam logic [3:0] CT = 4'd9;

  always #2 clk = ~clk;

  ipc_mailbox u0 (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq), .a_nmi(a_nmi),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq), .b_nmi(b_nmi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit s, input logic [3:0] ad, input logic [31:0] d);
    if (!s) begin a_wr = 1; a_addr = ad; a_wdata = d; end
    else    begin b_wr = 1; b_addr = ad; b_wdata = d; end
  endtask

  task automatic idle();
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
  endtask

  task automatic bus_wr(input bit s, input logic [3:0] ad, input logic [31:0] d);
    @(negedge clk); drive(s, ad, d);
    @(negedge clk); idle();
  endtask

  task automatic bus_rd(input bit s, input logic [3:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (!s) begin a_rd = 1; a_addr = ad; end
    else    begin b_rd = 1; b_addr = ad; end
    #1 d = s ? b_rdata : a_rdata;
    @(negedge clk); idle();
  endtask

  task automatic peek(input bit s, input logic [3:0] ad, output logic [31:0] d);
    if (!s) a_addr = ad; else b_addr = ad;
    #1 d = s ? b_rdata : a_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(0, ST, d); chk("R1 A status", d, 32'hF0);
    peek(1, ST, d); chk("R1 B status", d, 32'hF0);
    peek(0, CT, d); chk("R1 A control", d, 32'h0);
    chk("R1 irq/nmi", {28'd0, a_irq, a_nmi, b_irq, b_nmi}, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    bus_wr(0, 4'd1, 32'hCAFE0001);
    peek(0, ST, d); chk("R2 A empty1 cleared", d, 32'hB0);
    peek(1, ST, d); chk("R2 B full1 set", d, 32'hF4);
    bus_rd(1, 4'd5, d); chk("R3 B reads slot1", d, 32'hCAFE0001);
    peek(1, ST, d); chk("R3 B full1 cleared", d, 32'hF0);
    peek(0, ST, d); chk("R3 A empty1 restored", d, 32'hF0);
  endtask

  task automatic t_mixed();
    logic [31:0] d;
    bus_wr(0, 4'd0, 32'h11110000);
    bus_wr(0, 4'd3, 32'h33330003);
    bus_wr(1, 4'd2, 32'h2222BBBB);
    peek(0, ST, d); chk("R4 A status mixed", d, 32'h62);
    peek(1, ST, d); chk("R4 B status mixed", d, 32'hD9);
    bus_rd(0, 4'd6, d); chk("R4 A reads slot2", d, 32'h2222BBBB);
    bus_rd(1, 4'd7, d); chk("R4 B reads slot3", d, 32'h33330003);
    peek(1, ST, d); chk("R4 B status after slot3", d, 32'hF8);
    bus_rd(1, 4'd4, d); chk("R4 B reads slot0", d, 32'h11110000);
    peek(0, ST, d); chk("R4 A drained", d, 32'hF0);
    peek(1, ST, d); chk("R4 B drained", d, 32'hF0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    bus_wr(0, CT, 32'h5);
    peek(0, ST, d); chk("R5 busy cycle1", d, 32'h1F0);
    peek(1, ST, d); chk("R5 peer old flags", d, 32'hF0);
    @(negedge clk);
    peek(0, ST, d); chk("R5 busy cycle2", d, 32'h1F0);
    @(negedge clk);
    peek(0, ST, d); chk("R5 busy dropped", d, 32'hF0);
    peek(1, ST, d); chk("R5 peer new flags", d, 32'hAF0);
  endtask

  task automatic t_flag_lock();
    logic [31:0] d;
    @(negedge clk); drive(0, CT, 32'h2);
    @(negedge clk); drive(0, CT, 32'h7);
    @(negedge clk); idle();
    @(negedge clk); @(negedge clk);
    peek(1, ST, d); chk("R6 peer kept first value", d, 32'h4F0);
    peek(0, CT, d); chk("R6 writer kept first value", d, 32'h2);
    bus_wr(0, CT, 32'h7);
    @(negedge clk); @(negedge clk);
    peek(1, ST, d); chk("R6 later write accepted", d, 32'hEF0);
  endtask

  task automatic t_gint();
    logic [31:0] d;
    bus_wr(0, CT, 32'h47);
    peek(0, CT, d); chk("R7 sender sees pending", (d >> 4) & 32'h1F, 32'h4);
    peek(1, ST, d); chk("R7 peer sees pending", (d >> 12) & 32'h1F, 32'h4);
    bus_wr(0, CT, 32'h07);
    peek(0, CT, d); chk("R7 zero write no effect", (d >> 4) & 32'h1F, 32'h4);
    chk("R10 irq off without enable", {31'd0, b_irq}, 32'h0);
    bus_wr(1, CT, 32'h800);
    chk("R10 irq from pending request", {31'd0, b_irq}, 32'h1);
    bus_wr(1, ST, 32'h4000);
    peek(0, CT, d); chk("R8 sender cleared", (d >> 4) & 32'h1F, 32'h0);
    peek(1, ST, d); chk("R8 peer cleared", (d >> 12) & 32'h1F, 32'h0);
    chk("R8 irq dropped", {31'd0, b_irq}, 32'h0);
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    bus_wr(0, CT, 32'h107);
    chk("R9 nmi raised on B", {30'd0, b_nmi, a_nmi}, 32'h2);
    peek(1, ST, d); chk("R9 peer status bit16", (d >> 16) & 32'h1, 32'h1);
    bus_wr(1, ST, 32'h10000);
    chk("R9 nmi cleared", {31'd0, b_nmi}, 32'h0);
    peek(0, CT, d); chk("R9 sender bit8 cleared", (d >> 8) & 32'h1, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_wr(1, CT, 32'h200);
    chk("R10 full enable, nothing full", {31'd0, b_irq}, 32'h0);
    bus_wr(0, 4'd0, 32'hA5A5A5A5);
    chk("R10 irq on full", {31'd0, b_irq}, 32'h1);
    chk("R10 A irq still off", {31'd0, a_irq}, 32'h0);
    bus_wr(0, CT, 32'h407);
    chk("R10 A irq on empty", {31'd0, a_irq}, 32'h1);
    bus_rd(1, 4'd4, d); chk("R3 data for irq test", d, 32'hA5A5A5A5);
    chk("R10 B irq after drain", {31'd0, b_irq}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_mixed();
    t_flags();
    t_flag_lock();
    t_gint();
    t_nmi();
    t_irq();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule